// File: doc/BRIEF.md
# PTP Event Timestamp Capture

This block sits beside a receive or transmit datapath and watches the PTP frames that pass through it as a byte stream with start and end markers. The PTP header starts at a fixed byte offset from the start of the frame. The block reads the field that gives the message type, using either the version 1 header layout or the 2008 header layout as a configuration input selects. If the frame is an event message, the block copies the system time from the first byte of the frame into a message snapshot register.

A rising edge on an auxiliary trigger input fills a second snapshot register in the same way. Each snapshot has its own lock. After a capture, the register holds its value and its event flag stays set. The next acknowledge pulse clears both. Any trigger that arrives while a snapshot is locked is discarded, and a sticky drop flag records it. This lets software read a stable timestamp at its own pace.

Top module: `ptp_ts_snap`

## Requirements
- R1: After reset, both event flags, both drop flags and both snapshot registers are zero.
- R2: With `cfg_v2` = 0, the message type is the whole byte at header offset 32, which is frame byte `HDR_OFS`+32. Only the values 0 and 1 cause a capture. The values 2 to 255 never do.
- R3: With `cfg_v2` = 1, the message type is the low nibble of header offset 0, which is frame byte `HDR_OFS`. The values 0 to 3 cause a capture and the values 4 to 15 never do. The high nibble of that byte has no effect.
- R4: `cfg_v2` alone selects which of the two byte positions is decoded. The same frame can capture under one setting and not under the other.
- R5: A frame whose end marker arrives before the type byte causes no capture.
- R6: A message capture loads `msg_snap` with the `sys_time` value present in the start-of-frame beat. `msg_evt` and `msg_snap` take their new values at the second rising edge after the end-of-frame beat.
- R7: `aux_in` passes through `SYNC_STAGES` synchronizer flops before edge detection. A low-to-high change captures the `sys_time` value from `SYNC_STAGES` cycles after the first high cycle. Holding `aux_in` high causes no further capture.
- R8: While an event flag is set, a further trigger for that source leaves the snapshot unchanged and sets the drop flag for that source. The drop flag stays set until that source is cleared.
- R9: A one-cycle clear pulse (`clr_msg` or `clr_aux`) resets that source's event and drop flags at the next edge.
- R10: A trigger in the same cycle as the clear for its source is accepted. It loads a new snapshot, the event flag stays set, and the drop flag ends at zero.
- R11: The two sources are independent. A trigger or clear on one source never changes the other source's snapshot or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_v2 | input | 1 | Header layout: 0 = version 1, 1 = 2008 |
| rx_valid | input | 1 | Byte stream beat valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| aux_in | input | 1 | Asynchronous auxiliary trigger |
| sys_time | input | TIME_W | Free-running system time |
| clr_msg | input | 1 | Acknowledge pulse for the message snapshot |
| clr_aux | input | 1 | Acknowledge pulse for the auxiliary snapshot |
| msg_snap | output | TIME_W | Message timestamp snapshot |
| msg_evt | output | 1 | Message snapshot locked |
| msg_drop | output | 1 | Message trigger lost while locked |
| aux_snap | output | TIME_W | Auxiliary timestamp snapshot |
| aux_evt | output | 1 | Auxiliary snapshot locked |
| aux_drop | output | 1 | Auxiliary trigger lost while locked |

## Verification
The hardest case to reach from the ports is a trigger that lands in exactly the cycle of the acknowledge pulse. For the message source, this trigger is the registered end-of-frame decision, which is internal. The bench asserts `clr_msg` in the beat right after the end-of-frame byte, which lines the pulse up with that internal decision. The bench also sweeps every type byte value under both header layouts, and it counts synchronizer cycles to predict the auxiliary snapshot value.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;

  typedef enum logic {
    HDR_V1 = 1'b0,
    HDR_V2 = 1'b1
  } hdr_ver_e;

  localparam int unsigned V1_TYPE_OFS = 32;
  localparam int unsigned V2_TYPE_OFS = 0;

  // True when the type byte marks an event message for the given layout.
  function automatic logic is_event_msg(hdr_ver_e ver, logic [7:0] type_byte);
    logic hit;
    if (ver == HDR_V1) begin
      hit = (type_byte == 8'd0) || (type_byte == 8'd1);
    end else begin
      hit = (type_byte[3:0] <= 4'd3);
    end
    return hit;
  endfunction

endpackage

// File: rtl/ptp_frame_qual.sv
module ptp_frame_qual
  import ptp_snap_pkg::*;
#(
  parameter int unsigned TIME_W  = 32,
  parameter int unsigned HDR_OFS = 42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_v2,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [TIME_W-1:0] sys_time,
  output logic              hit,
  output logic [TIME_W-1:0] hit_time
);

  localparam int unsigned V1_IDX  = HDR_OFS + V1_TYPE_OFS;
  localparam int unsigned V2_IDX  = HDR_OFS + V2_TYPE_OFS;
  localparam int unsigned CNT_MAX = V1_IDX + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              in_frame_q;
  logic              qual_q;
  logic              hit_q;
  logic [TIME_W-1:0] sof_time_q;

  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  type_idx;
  logic              active;
  logic              at_type;
  logic              qual_now;
  hdr_ver_e          ver;

  always_comb begin
    ver      = hdr_ver_e'(cfg_v2);
    active   = rx_valid && (rx_sof || in_frame_q);
    idx      = rx_sof ? '0 : cnt_q;
    type_idx = (ver == HDR_V2) ? CNT_W'(V2_IDX) : CNT_W'(V1_IDX);
    at_type  = active && (idx == type_idx);
    if (at_type) begin
      qual_now = is_event_msg(ver, rx_data);
    end else begin
      qual_now = qual_q && !rx_sof;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      qual_q     <= 1'b0;
      hit_q      <= 1'b0;
      sof_time_q <= '0;
    end else begin
      hit_q <= active && rx_eof && qual_now;
      if (rx_valid && rx_sof) begin
        sof_time_q <= sys_time;
        cnt_q      <= CNT_W'(1);
      end else if (active && (cnt_q != CNT_W'(CNT_MAX))) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (active) begin
        in_frame_q <= !rx_eof;
        qual_q     <= qual_now;
      end
    end
  end

  assign hit      = hit_q;
  assign hit_time = sof_time_q;

endmodule

// File: rtl/ptp_aux_edge.sv
module ptp_aux_edge #(
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aux_in,
  input  logic [TIME_W-1:0] sys_time,
  output logic              hit,
  output logic [TIME_W-1:0] hit_time
);

  logic [SYNC_STAGES:0] chain_q;
  logic                 rise;
  logic                 hit_q;
  logic [TIME_W-1:0]    time_q;

  assign rise = chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      hit_q   <= 1'b0;
      time_q  <= '0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-1:0], aux_in};
      hit_q   <= rise;
      time_q  <= sys_time;
    end
  end

  assign hit      = hit_q;
  assign hit_time = time_q;

endmodule

// File: rtl/ptp_snap_slot.sv
module ptp_snap_slot #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [TIME_W-1:0] trig_time,
  input  logic              clr,
  output logic [TIME_W-1:0] snap,
  output logic              evt,
  output logic              drop
);

  logic [TIME_W-1:0] snap_q;
  logic              evt_q;
  logic              drop_q;
  logic              take;

  assign take = trig && (!evt_q || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      evt_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (take) begin
        snap_q <= trig_time;
        evt_q  <= 1'b1;
      end else if (clr) begin
        evt_q <= 1'b0;
      end
      if (clr) begin
        drop_q <= 1'b0;
      end else if (trig && evt_q) begin
        drop_q <= 1'b1;
      end
    end
  end

  assign snap = snap_q;
  assign evt  = evt_q;
  assign drop = drop_q;

endmodule

// File: rtl/ptp_ts_snap.sv
module ptp_ts_snap
  import ptp_snap_pkg::*;
#(
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned HDR_OFS     = 42,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_v2,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              aux_in,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              clr_msg,
  input  logic              clr_aux,
  output logic [TIME_W-1:0] msg_snap,
  output logic              msg_evt,
  output logic              msg_drop,
  output logic [TIME_W-1:0] aux_snap,
  output logic              aux_evt,
  output logic              aux_drop
);

  localparam int unsigned NSRC    = 2;
  localparam int unsigned SRC_MSG = 0;
  localparam int unsigned SRC_AUX = 1;

  logic              msg_hit;
  logic              aux_hit;
  logic [TIME_W-1:0] msg_hit_time;
  logic [TIME_W-1:0] aux_hit_time;

  logic              src_trig [NSRC];
  logic [TIME_W-1:0] src_time [NSRC];
  logic              src_clr  [NSRC];
  logic [TIME_W-1:0] src_snap [NSRC];
  logic              src_evt  [NSRC];
  logic              src_drop [NSRC];

  ptp_frame_qual #(
    .TIME_W (TIME_W),
    .HDR_OFS(HDR_OFS)
  ) u_qual (
    .clk     (clk),
    .rst     (rst),
    .cfg_v2  (cfg_v2),
    .rx_valid(rx_valid),
    .rx_sof  (rx_sof),
    .rx_eof  (rx_eof),
    .rx_data (rx_data),
    .sys_time(sys_time),
    .hit     (msg_hit),
    .hit_time(msg_hit_time)
  );

  ptp_aux_edge #(
    .TIME_W     (TIME_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_aux (
    .clk     (clk),
    .rst     (rst),
    .aux_in  (aux_in),
    .sys_time(sys_time),
    .hit     (aux_hit),
    .hit_time(aux_hit_time)
  );

  always_comb begin
    src_trig[SRC_MSG] = msg_hit;
    src_time[SRC_MSG] = msg_hit_time;
    src_clr[SRC_MSG]  = clr_msg;
    src_trig[SRC_AUX] = aux_hit;
    src_time[SRC_AUX] = aux_hit_time;
    src_clr[SRC_AUX]  = clr_aux;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    ptp_snap_slot #(
      .TIME_W(TIME_W)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .trig     (src_trig[s]),
      .trig_time(src_time[s]),
      .clr      (src_clr[s]),
      .snap     (src_snap[s]),
      .evt      (src_evt[s]),
      .drop     (src_drop[s])
    );
  end

  assign msg_snap = src_snap[SRC_MSG];
  assign msg_evt  = src_evt[SRC_MSG];
  assign msg_drop = src_drop[SRC_MSG];
  assign aux_snap = src_snap[SRC_AUX];
  assign aux_evt  = src_evt[SRC_AUX];
  assign aux_drop = src_drop[SRC_AUX];

endmodule

// File: rtl/ptp_ts_snap_chk.sv
module ptp_ts_snap_chk #(
  parameter int unsigned TIME_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_msg,
  input logic              clr_aux,
  input logic              msg_hit,
  input logic              aux_hit,
  input logic [TIME_W-1:0] msg_hit_time,
  input logic [TIME_W-1:0] aux_hit_time,
  input logic [TIME_W-1:0] msg_snap,
  input logic [TIME_W-1:0] aux_snap,
  input logic              msg_evt,
  input logic              aux_evt,
  input logic              msg_drop,
  input logic              aux_drop
);

  AST_MSG_TAKE: assert property (@(posedge clk) disable iff (rst)
    msg_hit && (!msg_evt || clr_msg) |=> msg_evt && (msg_snap == $past(msg_hit_time))); // R6
  AST_AUX_TAKE: assert property (@(posedge clk) disable iff (rst)
    aux_hit && (!aux_evt || clr_aux) |=> aux_evt && (aux_snap == $past(aux_hit_time))); // R10
  AST_MSG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    msg_evt && !clr_msg |=> msg_evt && $stable(msg_snap)); // R8
  AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    aux_evt && !clr_aux |=> aux_evt && $stable(aux_snap)); // R8
  AST_MSG_DROP_SET: assert property (@(posedge clk) disable iff (rst)
    msg_evt && msg_hit && !clr_msg |=> msg_drop); // R8
  AST_AUX_DROP_KEEP: assert property (@(posedge clk) disable iff (rst)
    aux_drop && !clr_aux |=> aux_drop); // R8
  AST_MSG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_msg && !msg_hit |=> !msg_evt && !msg_drop); // R9
  AST_AUX_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_aux && !aux_hit |=> !aux_evt && !aux_drop); // R9
  AST_AUX_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    aux_hit |=> !aux_hit); // R7
  AST_MSG_IDLE_KEEPS_AUX: assert property (@(posedge clk) disable iff (rst)
    !aux_hit && !clr_aux |=> $stable(aux_evt)); // R11

endmodule

bind ptp_ts_snap ptp_ts_snap_chk #(
  .TIME_W(TIME_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_msg     (clr_msg),
  .clr_aux     (clr_aux),
  .msg_hit     (msg_hit),
  .aux_hit     (aux_hit),
  .msg_hit_time(msg_hit_time),
  .aux_hit_time(aux_hit_time),
  .msg_snap    (msg_snap),
  .aux_snap    (aux_snap),
  .msg_evt     (msg_evt),
  .aux_evt     (aux_evt),
  .msg_drop    (msg_drop),
  .aux_drop    (aux_drop)
);

// File: tb/ptp_ts_snap_tb.sv
module ptp_ts_snap_tb_top;

  localparam int unsigned TIME_W  = 32;
  localparam int unsigned HDR_OFS = 6;
  localparam int unsigned SYNC    = 2;
  localparam time         CLK_PER = 10ns;
  localparam int unsigned V1_POS  = HDR_OFS + 32;
  localparam int unsigned V2_POS  = HDR_OFS;
  localparam int unsigned FLEN    = V1_POS + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_v2 = 1'b0;
  logic              rx_valid = 1'b0;
  logic              rx_sof = 1'b0;
  logic              rx_eof = 1'b0;
  logic [7:0]        rx_data = 8'h00;
  logic              aux_in = 1'b0;
  logic [TIME_W-1:0] sys_time = 32'h1000_0000;
  logic              clr_msg = 1'b0;
  logic              clr_aux = 1'b0;
  logic [TIME_W-1:0] msg_snap, aux_snap;
  logic              msg_evt, msg_drop, aux_evt, aux_drop;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;
  always @(posedge clk) sys_time <= sys_time + 32'd1;

  ptp_ts_snap #(
    .TIME_W     (TIME_W),
    .HDR_OFS    (HDR_OFS),
    .SYNC_STAGES(SYNC)
  ) dut_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_v2  (cfg_v2),
    .rx_valid(rx_valid),
    .rx_sof  (rx_sof),
    .rx_eof  (rx_eof),
    .rx_data (rx_data),
    .aux_in  (aux_in),
    .sys_time(sys_time),
    .clr_msg (clr_msg),
    .clr_aux (clr_aux),
    .msg_snap(msg_snap),
    .msg_evt (msg_evt),
    .msg_drop(msg_drop),
    .aux_snap(aux_snap),
    .aux_evt (aux_evt),
    .aux_drop(aux_drop)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Sends one frame; pos/val place the type byte. If clr_at_end, clr_msg is
  // raised in the beat after the last byte. Returns sys_time of the first beat.
  task automatic send_frame(int len, int pos, logic [7:0] val, bit clr_at_end,
                            output logic [TIME_W-1:0] t0);
    t0 = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = (i == pos) ? val : 8'hA5;
      if (i == 0) t0 = sys_time;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
    rx_eof   = 1'b0;
    clr_msg  = clr_at_end;
    @(negedge clk);
    clr_msg  = 1'b0;
  endtask

  task automatic pulse_clr(bit m, bit a);
    @(negedge clk);
    clr_msg = m;
    clr_aux = a;
    @(negedge clk);
    clr_msg = 1'b0;
    clr_aux = 1'b0;
  endtask

  function automatic bit exp_event(bit v2, int val);
    if (v2) return (val % 16) < 4;
    return (val == 0) || (val == 1);
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TIME_W-1:0] t0, t1, ta, held;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1", "msg_evt", msg_evt, 0);
    check("R1", "msg_drop", msg_drop, 0);
    check("R1", "msg_snap", msg_snap, 0);
    check("R1", "aux_evt", aux_evt, 0);
    check("R1", "aux_drop", aux_drop, 0);
    check("R1", "aux_snap", aux_snap, 0);

    // R2 / R3 full sweep of type byte values under both layouts
    for (int ver = 0; ver < 2; ver++) begin
      cfg_v2 = ver[0];
      for (int v = 0; v < 256; v++) begin
        bit e;
        e = exp_event(ver[0], v);
        send_frame(FLEN, ver[0] ? V2_POS : V1_POS, v[7:0], 1'b0, t0);
        check(ver[0] ? "R3" : "R2", "evt", msg_evt, e);
        if (e) check("R6", "snap", msg_snap, t0);
        check("R8", "drop", msg_drop, 0);
        pulse_clr(1'b1, 1'b0);
        check("R9", "evt cleared", msg_evt, 0);
      end
    end

    // R4 same bytes, different layout selection
    cfg_v2 = 1'b0;
    send_frame(FLEN, V2_POS, 8'h02, 1'b0, t0);
    check("R4", "v1 ignores byte0", msg_evt, 0);
    cfg_v2 = 1'b1;
    send_frame(FLEN, V2_POS, 8'h02, 1'b0, t0);
    check("R4", "v2 decodes byte0", msg_evt, 1);
    check("R4", "v2 snap", msg_snap, t0);
    pulse_clr(1'b1, 1'b0);

    // R5 frame ends before the version 1 type byte
    cfg_v2 = 1'b0;
    send_frame(V1_POS, V1_POS, 8'h00, 1'b0, t0);
    check("R5", "short frame", msg_evt, 0);

    // R8 lock: second qualifying frame is discarded
    send_frame(FLEN, V1_POS, 8'h00, 1'b0, t0);
    check("R6", "first capture", msg_snap, t0);
    send_frame(FLEN, V1_POS, 8'h01, 1'b0, t1);
    check("R8", "snap kept", msg_snap, t0);
    check("R8", "evt kept", msg_evt, 1);
    check("R8", "drop set", msg_drop, 1);
    pulse_clr(1'b1, 1'b0);
    check("R9", "evt cleared", msg_evt, 0);
    check("R9", "drop cleared", msg_drop, 0);

    // R10 clear in the same cycle as a new trigger
    send_frame(FLEN, V1_POS, 8'h00, 1'b0, t0);
    send_frame(FLEN, V1_POS, 8'h01, 1'b1, t1);
    check("R10", "snap replaced", msg_snap, t1);
    check("R10", "evt held", msg_evt, 1);
    check("R10", "drop zero", msg_drop, 0);

    // R7 auxiliary capture, R11 independence from the locked message slot
    held = msg_snap;
    @(negedge clk);
    aux_in = 1'b1;
    ta = sys_time;
    step(SYNC + 4);
    check("R7", "aux evt", aux_evt, 1);
    check("R7", "aux snap", aux_snap, ta + SYNC);
    check("R11", "msg snap untouched", msg_snap, held);
    check("R11", "msg drop untouched", msg_drop, 0);
    pulse_clr(1'b0, 1'b1);
    step(4);
    check("R7", "held high no retrigger", aux_evt, 0);
    check("R11", "msg evt after aux clear", msg_evt, 1);
    aux_in = 1'b0;
    step(SYNC + 2);
    aux_in = 1'b1;
    ta = sys_time;
    step(SYNC + 4);
    check("R7", "second rise", aux_snap, ta + SYNC);
    aux_in = 1'b0;
    step(SYNC + 2);
    aux_in = 1'b1;
    step(SYNC + 4);
    check("R8", "aux locked snap", aux_snap, ta + SYNC);
    check("R8", "aux drop", aux_drop, 1);
    pulse_clr(1'b1, 1'b0);
    check("R11", "aux evt after msg clear", aux_evt, 1);
    check("R9", "msg evt cleared", msg_evt, 0);
    pulse_clr(1'b0, 1'b1);
    check("R9", "aux drop cleared", aux_drop, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule